// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block holds a bank of sixteen address index registers, each paired with its own modifier, base and length register. In one clock it applies a standalone update to one index register. No memory access is made. The update is either a modify or a bit-reverse. A modify adds an immediate or a chosen modifier register to the index. When a buffer is set up for that index, the result wraps back into the buffer. A bit-reverse adds an immediate, mirrors the full 32-bit sum end for end, and writes the mirrored value back.

Software loads the four register kinds through a write port and observes them through a combinational read port. Operations arrive on a command port made of an opcode, a target index, a modifier select and an immediate. Two mode inputs are present so that the block can sit inside a larger address unit: a data-width (SIMD) flag and a global bit-reverse mode flag. Neither of them changes the addresses the block computes.

Top module: `agen_core`

## Requirements
- R1: While the reset is asserted, and until the first command after its release, every index, modifier, base and length register reads as zero.
- R2: A write with `wr_en` high loads `wr_data` into the register named by `wr_sel`, in the bank chosen by `wr_kind` (0 = index, 1 = modifier, 2 = base, 3 = length). The read port shows the new value after the next rising clock edge.
- R3: Opcode 1 (modify by immediate) on an index whose length is zero writes `I + imm` to that index, taken modulo 2^32.
- R4: Opcode 2 (modify by register) adds the modifier register selected by `cmd_msel` to the target index. This uses the same wrap rules as opcode 1.
- R5: With a nonzero length L and base B, a modify whose sum is at or above B+L stores sum − L. A sum inside [B, B+L) is stored unchanged.
- R6: With a nonzero length L and base B, a modify whose sum is below B stores sum + L.
- R7: Opcode 3 (bit-reverse) stores the 32-bit mirror of `I + imm`, so that bit k of the sum goes to bit 31−k. No circular wrap is applied, whatever the base and length.
- R8: The `simd_en` and `brev_mode` inputs have no effect on any stored result.
- R9: An operation changes only its target index register. All other index registers and all modifier, base and length registers keep their values.
- R10: When an operation and an index write target the same index in the same cycle, the operation's result is stored. A write to a different index in that cycle still takes effect.
- R11: Opcode 0 leaves every register unchanged, whatever the other command fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_op | input | 2 | Opcode: 0 none, 1 modify by immediate, 2 modify by register, 3 bit-reverse |
| cmd_isel | input | 4 | Target index register |
| cmd_msel | input | 4 | Modifier register used by opcode 2 |
| cmd_imm | input | 32 | Immediate operand |
| simd_en | input | 1 | Data-width mode flag; does not affect addresses |
| brev_mode | input | 1 | Global bit-reverse mode flag; does not affect any operation |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Bank selected for a write: 0 index, 1 modifier, 2 base, 3 length |
| wr_sel | input | 4 | Register number within the bank for a write |
| wr_data | input | 32 | Write value |
| rd_kind | input | 2 | Bank selected for a read |
| rd_sel | input | 4 | Register number within the bank for a read |
| rd_data | output | 32 | Combinational read value |

## Verification
The modify path is tested with small forward steps, with a step that crosses 2^32 while the length is zero, and with negative modifier-register values. Together these separate the two operand sources and show plain modulo arithmetic. With a buffer configured, the tests place sums just below the top, exactly on B+L, just below B, and well inside the buffer. This exposes off-by-one errors in either wrap comparison and any wrap applied where none is due. Bit-reverse inputs put a single set bit near each end and in the middle, and they run with a buffer configured. This separates a full-width mirror from a partial one, and it shows whether circular logic leaks into the reverse path. Repeated operations with both mode flags raised, same-cycle write collisions and idle opcodes carrying live fields check the isolation requirements.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_MOD_IMM = 2'd1,
    OP_MOD_REG = 2'd2,
    OP_BREV    = 2'd3
  } agen_op_e;

  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_BASE = 2'd2,
    KIND_LEN  = 2'd3
  } agen_kind_e;
endpackage

// File: rtl/agen_regbank.sv
module agen_regbank #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [SW-1:0]            wr_sel,
  input  logic [DW-1:0]            wr_data,
  input  logic                     upd_en,
  input  logic [SW-1:0]            upd_sel,
  input  logic [DW-1:0]            upd_val,
  output logic [NREG-1:0][DW-1:0]  idx_q,
  output logic [NREG-1:0][DW-1:0]  mod_q,
  output logic [NREG-1:0][DW-1:0]  base_q,
  output logic [NREG-1:0][DW-1:0]  len_q
);
  import agen_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic          wr_hit;
    logic          upd_hit;
    logic          idx_en, mod_en, base_en, len_en;
    logic [DW-1:0] idx_d;

    always_comb begin
      wr_hit  = wr_en && (wr_sel == SW'(g));
      upd_hit = upd_en && (upd_sel == SW'(g));
      idx_en  = upd_hit || (wr_hit && wr_kind == KIND_IDX);
      mod_en  = wr_hit && wr_kind == KIND_MOD;
      base_en = wr_hit && wr_kind == KIND_BASE;
      len_en  = wr_hit && wr_kind == KIND_LEN;
      idx_d   = upd_hit ? upd_val : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        mod_q[g]  <= '0;
        base_q[g] <= '0;
        len_q[g]  <= '0;
      end else begin
        if (idx_en)  idx_q[g]  <= idx_d;
        if (mod_en)  mod_q[g]  <= wr_data;
        if (base_en) base_q[g] <= wr_data;
        if (len_en)  len_q[g]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/agen_circ.sv
module agen_circ #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] len,
  output logic [DW-1:0] result
);
  logic [DW-1:0] sum;
  logic [DW-1:0] top;
  logic          buf_on;

  always_comb begin
    sum    = idx + step;
    top    = base + len;
    buf_on = |len;
    result = sum;
    if (buf_on) begin
      if (sum >= top)       result = sum - len;
      else if (sum < base)  result = sum + len;
    end
  end
endmodule

// File: rtl/agen_brev.sv
module agen_brev #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] result
);
  logic [DW-1:0] sum;

  assign sum = idx + step;

  for (genvar k = 0; k < DW; k++) begin : g_bit
    assign result[k] = sum[DW-1-k];
  end
endmodule

// File: rtl/agen_core.sv
module agen_core #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_op,
  input  logic [SW-1:0] cmd_isel,
  input  logic [SW-1:0] cmd_msel,
  input  logic [DW-1:0] cmd_imm,
  input  logic          simd_en,
  input  logic          brev_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data
);
  import agen_pkg::*;

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [NREG-1:0][DW-1:0] idx_q, mod_q, base_q, len_q;
  logic [DW-1:0]           cur_idx, step, circ_res, brev_res, upd_val;
  logic                    upd_en;
  agen_op_e                op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    op      = agen_op_e'(cmd_op);
    cur_idx = idx_q[cmd_isel];
    step    = (op == OP_MOD_REG) ? mod_q[cmd_msel] : cmd_imm;
    upd_en  = (op != OP_NONE);
    upd_val = (op == OP_BREV) ? brev_res : circ_res;
  end

  agen_circ #(.DW(DW)) i_circ (
    .idx(cur_idx), .step(step), .base(base_q[cmd_isel]),
    .len(len_q[cmd_isel]), .result(circ_res)
  );

  agen_brev #(.DW(DW)) i_brev (
    .idx(cur_idx), .step(cmd_imm), .result(brev_res)
  );

  agen_regbank #(.NREG(NREG), .DW(DW)) i_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(upd_en), .upd_sel(cmd_isel), .upd_val(upd_val),
    .idx_q(idx_q), .mod_q(mod_q), .base_q(base_q), .len_q(len_q)
  );

  always_comb begin
    unique case (agen_kind_e'(rd_kind))
      KIND_IDX:  rd_data = idx_q[rd_sel];
      KIND_MOD:  rd_data = mod_q[rd_sel];
      KIND_BASE: rd_data = base_q[rd_sel];
      default:   rd_data = len_q[rd_sel];
    endcase
  end
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_ok,
  input logic [1:0]              cmd_op,
  input logic [SW-1:0]           cmd_isel,
  input logic [DW-1:0]           cmd_imm,
  input logic                    simd_en,
  input logic                    brev_mode,
  input logic                    wr_en,
  input logic [1:0]              wr_kind,
  input logic [SW-1:0]           wr_sel,
  input logic [NREG-1:0][DW-1:0] idx_q,
  input logic [NREG-1:0][DW-1:0] mod_q,
  input logic [NREG-1:0][DW-1:0] base_q,
  input logic [NREG-1:0][DW-1:0] len_q
);
  function automatic logic [DW-1:0] mirror(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int k = 0; k < DW; k++) r[k] = v[DW-1-k];
    return r;
  endfunction

  logic mode_flags;
  assign mode_flags = simd_en ^ brev_mode;

  // R1: held in reset, every bank is cleared by the next edge
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (idx_q == '0 && mod_q == '0 && base_q == '0 && len_q == '0));

  // R11: idle opcode with no write leaves index bank alone
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_op == 2'd0 && !wr_en) |=> $stable(idx_q));

  // R9: no write means modifier, base and length banks never move
  p_side_banks_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> ($stable(mod_q) && $stable(base_q) && $stable(len_q)));

  // R3: plain modify when the length is zero
  p_plain_modify_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_op == 2'd1 && len_q[cmd_isel] == '0) |=>
      idx_q[$past(cmd_isel)] == $past(idx_q[cmd_isel]) + $past(cmd_imm));

  // R7 and R8: reverse result is independent of the mode flags
  p_brev_mirror_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_op == 2'd3) |=>
      idx_q[$past(cmd_isel)] == mirror($past(idx_q[cmd_isel]) + $past(cmd_imm)));

  // R10: a colliding index write loses to the operation
  p_op_wins_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_op == 2'd3 && wr_en && wr_kind == 2'd0 && wr_sel == cmd_isel) |=>
      idx_q[$past(cmd_isel)] == mirror($past(idx_q[cmd_isel]) + $past(cmd_imm)));

  // R8: mode flags are observed only, never a trigger
  p_flags_known_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !$isunknown(mode_flags));
endmodule

bind agen_core agen_checker #(.NREG(NREG), .DW(DW)) i_agen_checker (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_sync_n),
  .cmd_op(cmd_op), .cmd_isel(cmd_isel), .cmd_imm(cmd_imm),
  .simd_en(simd_en), .brev_mode(brev_mode),
  .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
  .idx_q(idx_q), .mod_q(mod_q), .base_q(base_q), .len_q(len_q)
);

// File: tb/test_agen_core.sv
`timescale 1ns/1ps
module test_agen_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_isel, cmd_msel;
  logic [31:0] cmd_imm;
  logic        simd_en, brev_mode;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_kind;
  logic [3:0]  rd_sel;
  logic [31:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  agen_core i_agen_core (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_isel(cmd_isel),
    .cmd_msel(cmd_msel), .cmd_imm(cmd_imm), .simd_en(simd_en),
    .brev_mode(brev_mode), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_kind(rd_kind),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // op, I1, M2, B1, L1, imm, expected I1
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] i, m, b, l, imm, exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd1, 32'd100,        32'd0,          32'd0,   32'd0,  32'd4,          32'd104},        // R3
    '{2'd1, 32'hFFFF_FFFE,  32'd0,          32'd0,   32'd0,  32'd5,          32'd3},          // R3 modulo
    '{2'd2, 32'd10,         32'd7,          32'd0,   32'd0,  32'd0,          32'd17},         // R4
    '{2'd2, 32'd10,         32'hFFFF_FFFD,  32'd0,   32'd0,  32'd0,          32'd7},          // R4 negative
    '{2'd1, 32'd108,        32'd0,          32'd100, 32'd10, 32'd4,          32'd102},        // R5
    '{2'd1, 32'd109,        32'd0,          32'd100, 32'd10, 32'd1,          32'd100},        // R5 at B+L
    '{2'd1, 32'd102,        32'd0,          32'd100, 32'd10, 32'hFFFF_FFFC,  32'd108},        // R6
    '{2'd2, 32'd100,        32'hFFFF_FFFF,  32'd100, 32'd10, 32'd0,          32'd109},        // R6 via M
    '{2'd1, 32'd103,        32'd0,          32'd100, 32'd10, 32'd2,          32'd105},        // R5 inside
    '{2'd3, 32'd0,          32'd0,          32'd0,   32'd0,  32'd1,          32'h8000_0000},  // R7
    '{2'd3, 32'd4,          32'd0,          32'd0,   32'd0,  32'd4,          32'h1000_0000},  // R7
    '{2'd3, 32'h0000_FFFF,  32'd0,          32'd100, 32'd10, 32'd1,          32'h0000_8000}   // R7 no wrap
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic op(input logic [1:0] o, input logic [3:0] is, input logic [3:0] ms,
                    input logic [31:0] imm);
    @(negedge clk);
    cmd_op = o; cmd_isel = is; cmd_msel = ms; cmd_imm = imm;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic rd(input string tag, input logic [1:0] k, input logic [3:0] s,
                    input logic [31:0] exp);
    rd_kind = k; rd_sel = s;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_op = 2'd0; cmd_isel = '0; cmd_msel = '0; cmd_imm = '0;
    simd_en = 1'b0; brev_mode = 1'b0; wr_en = 1'b0; wr_kind = '0; wr_sel = '0;
    wr_data = '0; rd_kind = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    // R1: all banks zero in reset
    for (int k = 0; k < 4; k++) rd("R1 reset", 2'(k), 4'd7, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 16; s += 5) rd("R1 after release", 2'd0, 4'(s), 32'd0);

    // R2: write each bank and read it back
    wr(2'd1, 4'd9, 32'hA5A5_0001); rd("R2 modifier", 2'd1, 4'd9, 32'hA5A5_0001);
    wr(2'd2, 4'd9, 32'h0000_0200); rd("R2 base",     2'd2, 4'd9, 32'h0000_0200);
    wr(2'd3, 4'd9, 32'h0000_0040); rd("R2 length",   2'd3, 4'd9, 32'h0000_0040);
    wr(2'd0, 4'd9, 32'h0000_0210); rd("R2 index",    2'd0, 4'd9, 32'h0000_0210);

    // Vector table: R3 to R7
    for (int v = 0; v < 12; v++) begin
      wr(2'd0, 4'd1, VEC[v].i);
      wr(2'd1, 4'd2, VEC[v].m);
      wr(2'd2, 4'd1, VEC[v].b);
      wr(2'd3, 4'd1, VEC[v].l);
      op(VEC[v].op, 4'd1, 4'd2, VEC[v].imm);
      rd($sformatf("R3-7 vector %0d", v), 2'd0, 4'd1, VEC[v].exp);
    end

    // R9: last op touched I1 only
    rd("R9 base kept",   2'd2, 4'd1, 32'd100);
    rd("R9 length kept", 2'd3, 4'd1, 32'd10);
    rd("R9 other index", 2'd0, 4'd9, 32'h0000_0210);

    // R8: mode flags raised, same results
    simd_en = 1'b1; brev_mode = 1'b1;
    wr(2'd0, 4'd1, 32'd108);
    op(2'd1, 4'd1, 4'd0, 32'd4);
    rd("R8 modify with flags", 2'd0, 4'd1, 32'd102);
    wr(2'd0, 4'd1, 32'd0);
    op(2'd3, 4'd1, 4'd0, 32'd2);
    rd("R8 reverse with flags", 2'd0, 4'd1, 32'h4000_0000);
    simd_en = 1'b0; brev_mode = 1'b0;

    // R11: idle opcode with live fields
    wr(2'd0, 4'd5, 32'd55);
    @(negedge clk);
    cmd_op = 2'd0; cmd_isel = 4'd5; cmd_imm = 32'd999;
    @(negedge clk);
    rd("R11 idle", 2'd0, 4'd5, 32'd55);

    // R10: colliding write loses; write to another index wins
    wr(2'd0, 4'd3, 32'd20);
    @(negedge clk);
    cmd_op = 2'd1; cmd_isel = 4'd3; cmd_imm = 32'd1;
    wr_en = 1'b1; wr_kind = 2'd0; wr_sel = 4'd3; wr_data = 32'd777;
    @(negedge clk);
    cmd_op = 2'd0; wr_en = 1'b0;
    rd("R10 op wins", 2'd0, 4'd3, 32'd21);
    @(negedge clk);
    cmd_op = 2'd1; cmd_isel = 4'd3; cmd_imm = 32'd1;
    wr_en = 1'b1; wr_kind = 2'd0; wr_sel = 4'd4; wr_data = 32'd444;
    @(negedge clk);
    cmd_op = 2'd0; wr_en = 1'b0;
    rd("R10 op other", 2'd0, 4'd3, 32'd22);
    rd("R10 write other", 2'd0, 4'd4, 32'd444);

    finish_run();
  end
endmodule